// File: doc/BRIEF.md
# ADC Clock and Power Sequencer

This block is the digital control front end of an analog-to-digital converter. It holds a 32-bit control word that is loaded over a simple write strobe and read back at any time. It turns the system clock into an ADC clock enable, either by division or by following an external tick. It launches sampling in response to hardware or software triggers.

In low-power mode the analog section is switched off while nothing is pending. A trigger switches it on and waits a startup interval before sampling. A self-calibration cycle, started by one control bit, keeps the control word locked until it has ended. A modelled converter reports the end of each conversion with a one-cycle done strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0 and `ana_pwr_en`, `sample_start` and `cal_busy` are low while `adc_en` is low.
- R2: The control word holds a divide value in bits 7:0, the clock source select in bit 8 (0 = divided system clock, 1 = external tick) and low-power enable in bit 10. Calibration start is bit 30. Every other bit reads 0.
- R3: With bit 8 = 0, `adc_clk_en` is high in one system cycle out of every divide+1. A divide value of 0 keeps it high every cycle.
- R4: With bit 8 = 1, `adc_clk_en` equals `ext_clk_tick` in every cycle and the divide value has no effect.
- R5: An accepted trigger restarts the divider. Without low power and without bypass, `sample_start` pulses for one cycle, N*(divide+1)+1 cycles after the trigger cycle, with N = 1. With the external tick held high the divide term is taken as 0.
- R6: In divided-clock mode without low power, with `sync_bypass` high, `sample_start` pulses exactly 2 cycles after the cycle in which `hw_trig` rises.
- R7: With low power on, `ana_pwr_en` is low while idle. It goes high the cycle after an accepted trigger and goes low the cycle after `conv_done` when no trigger is pending. Without low power, `ana_pwr_en` follows `adc_en`.
- R8: With low power on and starting from power-off, the startup wait is N = 15 ADC clock ticks when `res10` = 0 and N = 30 ticks when `res10` = 1, with the timing formula of R5.
- R9: While `adc_en` is low, `ana_pwr_en` stays low and triggers are ignored.
- R10: A trigger that arrives during the startup wait or during a conversion is kept pending. After `conv_done` power stays on and the pending one is sampled with N = 1 and no new startup wait.
- R11: Writing a 1 to bit 30 raises `cal_busy` in the next cycle. Calibration then runs for CAL_TICKS ADC clock ticks (64 by default), after which bit 30 and `cal_busy` clear. Triggers are ignored while it is set.
- R12: Fields written together with the calibration start are stored. Writes made while calibration is busy have no effect.
- R13: `hw_trig` counts only on its rising edge. Every cycle in which `sw_trig` is high is one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read back |
| adc_en | input | 1 | Converter enable |
| res10 | input | 1 | 1 selects 10-bit resolution, 0 selects 12-bit |
| sync_bypass | input | 1 | Fixed two-cycle launch in divided-clock mode |
| hw_trig | input | 1 | Hardware trigger, rising edge |
| sw_trig | input | 1 | Software trigger, one per high cycle |
| ext_clk_tick | input | 1 | External ADC clock tick |
| conv_done | input | 1 | End-of-conversion strobe from the converter |
| ana_pwr_en | output | 1 | Analog section power enable |
| adc_clk_en | output | 1 | ADC clock enable |
| sample_start | output | 1 | One-cycle sample launch |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The hardest case to reach is a trigger that lands inside an active conversion while low power is on. It has to be kept pending, keep the analog supply up past `conv_done`, and be served without a second startup wait. The stimulus reaches it with a directed sequence: a software trigger is pulsed after the first sample launch, and the done strobe follows while the pending flag can only be seen through the power output and the timing of the next launch. Latencies for random divide values, clock sources, resolutions and bypass settings are compared against a formula in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int FLD_DIV_LSB = 0;
  localparam int FLD_SRC_BIT = 8;
  localparam int FLD_LP_BIT  = 10;
  localparam int FLD_CAL_BIT = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BYP,
    ST_CONV,
    ST_CAL
  } seq_state_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic             cal_done,
  output logic [DIV_W-1:0] div,
  output logic             ext_src,
  output logic             lp_mode,
  output logic             cal_req,
  output logic [31:0]      rdata
);

  logic [DIV_W-1:0] div_q, div_d;
  logic             src_q, src_d, lp_q, lp_d, cal_q, cal_d;

  always_comb begin
    div_d = div_q;
    src_d = src_q;
    lp_d  = lp_q;
    cal_d = cal_q;
    if (wr && !cal_q) begin
      div_d = wdata[FLD_DIV_LSB +: DIV_W];
      src_d = wdata[FLD_SRC_BIT];
      lp_d  = wdata[FLD_LP_BIT];
      cal_d = wdata[FLD_CAL_BIT];
    end else if (cal_done) begin
      cal_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      src_q <= 1'b0;
      lp_q  <= 1'b0;
      cal_q <= 1'b0;
    end else begin
      div_q <= div_d;
      src_q <= src_d;
      lp_q  <= lp_d;
      cal_q <= cal_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[FLD_DIV_LSB +: DIV_W] = div_q;
    rdata[FLD_SRC_BIT] = src_q;
    rdata[FLD_LP_BIT]  = lp_q;
    rdata[FLD_CAL_BIT] = cal_q;
  end

  assign div     = div_q;
  assign ext_src = src_q;
  assign lp_mode = lp_q;
  assign cal_req = cal_q;

endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_src,
  input  logic             ext_tick,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div);

  always_comb begin
    if (restart || wrap) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = ext_src ? ext_tick : wrap;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CAL_TICKS = 64,
  parameter int WAKE_12B  = 15,
  parameter int WAKE_10B  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic res10,
  input  logic sync_bypass,
  input  logic ext_src,
  input  logic lp_mode,
  input  logic cal_req,
  input  logic tick,
  input  logic hw_trig,
  input  logic sw_trig,
  input  logic conv_done,
  output logic restart,
  output logic sample_start,
  output logic ana_pwr_en,
  output logic cal_done
);

  localparam int MAXC = (CAL_TICKS > WAKE_10B) ?
                        ((CAL_TICKS > WAKE_12B) ? CAL_TICKS : WAKE_12B) :
                        ((WAKE_10B > WAKE_12B) ? WAKE_10B : WAKE_12B);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ONE_C  = CW'(1);
  localparam logic [CW-1:0] W12_C  = CW'(WAKE_12B);
  localparam logic [CW-1:0] W10_C  = CW'(WAKE_10B);
  localparam logic [CW-1:0] CALE_C = CW'(CAL_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, need_q, need_d;
  logic          pend_q, pend_d, smp_q, smp_d, hw_q;
  logic          trig, trig_ok, go, go_cold;

  assign trig    = (hw_trig && !hw_q) || sw_trig;
  assign trig_ok = trig && adc_en && !cal_req;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    need_d   = need_q;
    pend_d   = pend_q;
    smp_d    = 1'b0;
    restart  = 1'b0;
    cal_done = 1'b0;
    go       = 1'b0;
    go_cold  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cal_req) begin
          state_d = ST_CAL;
          cnt_d   = '0;
        end else if (trig_ok) begin
          go      = 1'b1;
          go_cold = lp_mode;
        end
      end
      ST_WAIT: begin
        if (trig_ok) pend_d = 1'b1;
        if (tick) begin
          if (cnt_q == need_q - ONE_C) begin
            smp_d   = 1'b1;
            state_d = ST_CONV;
          end else begin
            cnt_d = cnt_q + ONE_C;
          end
        end
      end
      ST_BYP: begin
        if (trig_ok) pend_d = 1'b1;
        smp_d   = 1'b1;
        state_d = ST_CONV;
      end
      ST_CONV: begin
        if (conv_done) begin
          if (pend_q) begin
            go     = 1'b1;
            pend_d = trig_ok;
          end else if (trig_ok) begin
            go = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (trig_ok) begin
          pend_d = 1'b1;
        end
      end
      ST_CAL: begin
        if (tick) begin
          if (cnt_q == CALE_C) begin
            cal_done = 1'b1;
            state_d  = ST_IDLE;
            cnt_d    = '0;
          end else begin
            cnt_d = cnt_q + ONE_C;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (go) begin
      restart = 1'b1;
      cnt_d   = '0;
      if (!go_cold && !ext_src && sync_bypass) begin
        state_d = ST_BYP;
      end else begin
        state_d = ST_WAIT;
        need_d  = go_cold ? (res10 ? W10_C : W12_C) : ONE_C;
      end
    end
    if (!adc_en && state_q != ST_CAL && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      smp_d   = 1'b0;
      restart = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      need_q  <= ONE_C;
      pend_q  <= 1'b0;
      smp_q   <= 1'b0;
      hw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      need_q  <= need_d;
      pend_q  <= pend_d;
      smp_q   <= smp_d;
      hw_q    <= hw_trig;
    end
  end

  assign sample_start = smp_q;
  assign ana_pwr_en   = adc_en && (!lp_mode || state_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_W     = 8,
  parameter int CAL_TICKS = 64,
  parameter int WAKE_12B  = 15,
  parameter int WAKE_10B  = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        adc_en,
  input  logic        res10,
  input  logic        sync_bypass,
  input  logic        hw_trig,
  input  logic        sw_trig,
  input  logic        ext_clk_tick,
  input  logic        conv_done,
  output logic        ana_pwr_en,
  output logic        adc_clk_en,
  output logic        sample_start,
  output logic        cal_busy
);

  logic [DIV_W-1:0] div;
  logic             ext_src, lp_mode, cal_req, cal_done, restart, tick;

  adc_seq_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .cal_done(cal_done), .div(div), .ext_src(ext_src),
    .lp_mode(lp_mode), .cal_req(cal_req), .rdata(reg_rdata)
  );

  adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div(div), .ext_src(ext_src),
    .ext_tick(ext_clk_tick), .restart(restart), .tick(tick)
  );

  adc_seq_fsm #(
    .CAL_TICKS(CAL_TICKS), .WAKE_12B(WAKE_12B), .WAKE_10B(WAKE_10B)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .res10(res10),
    .sync_bypass(sync_bypass), .ext_src(ext_src), .lp_mode(lp_mode),
    .cal_req(cal_req), .tick(tick), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .conv_done(conv_done), .restart(restart), .sample_start(sample_start),
    .ana_pwr_en(ana_pwr_en), .cal_done(cal_done)
  );

  assign adc_clk_en = tick;
  assign cal_busy   = cal_req;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        adc_en,
  input logic        ext_clk_tick,
  input logic        ana_pwr_en,
  input logic        adc_clk_en,
  input logic        sample_start,
  input logic        cal_busy
);

  p_pwr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |-> !ana_pwr_en);

  p_div_zero_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[8] && reg_rdata[7:0] == 8'd0) |-> adc_clk_en);

  p_ext_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[8] |-> (adc_clk_en == ext_clk_tick));

  p_locked_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && reg_wr) |=> $stable(reg_rdata[10:0]));

  p_cal_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(reg_wr && reg_wdata[30]));

  p_sample_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |-> $past(ana_pwr_en));

  p_sample_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |=> !sample_start);

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .adc_en(adc_en), .ext_clk_tick(ext_clk_tick),
  .ana_pwr_en(ana_pwr_en), .adc_clk_en(adc_clk_en),
  .sample_start(sample_start), .cal_busy(cal_busy)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        adc_en, res10, sync_bypass, hw_trig, sw_trig, ext_clk_tick, conv_done;
  logic        ana_pwr_en, adc_clk_en, sample_start, cal_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .adc_en(adc_en), .res10(res10),
    .sync_bypass(sync_bypass), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .ext_clk_tick(ext_clk_tick), .conv_done(conv_done),
    .ana_pwr_en(ana_pwr_en), .adc_clk_en(adc_clk_en),
    .sample_start(sample_start), .cal_busy(cal_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int dv, input bit ext, input bit lp,
                                 input bit r10, input bit byp);
    int n;
    if (!lp && !ext && byp) return 2;
    n = lp ? (r10 ? 30 : 15) : 1;
    return n * ((ext ? 0 : dv) + 1) + 1;
  endfunction

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic trig_meas(input bit hw, output int lat);
    if (hw) hw_trig = 1'b1;
    else    sw_trig = 1'b1;
    lat = -1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (k == 1) sw_trig = 1'b0;
      if (sample_start) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic done_conv();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, cnt, kk;
    bit seen;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_wr = 0; reg_wdata = '0; adc_en = 0; res10 = 0;
    sync_bypass = 0; hw_trig = 0; sw_trig = 0; ext_clk_tick = 1; conv_done = 0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 0);
    chk(!ana_pwr_en && !sample_start && !cal_busy, "R1 outputs",
        {ana_pwr_en, sample_start, cal_busy}, 0);

    // R2 field layout, unused bits read zero
    wr(32'hBFFF_FFFF);
    chk(reg_rdata == 32'h0000_05FF, "R2 layout", reg_rdata, 32'h5FF);

    // R3 divide rate
    wr(32'h0000_0003);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += adc_clk_en; end
    chk(cnt == 10, "R3 div3 ticks", cnt, 10);
    wr(32'h0000_0000);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += adc_clk_en; end
    chk(cnt == 40, "R3 div0 ticks", cnt, 40);

    // R4 external tick, divide ignored
    wr(32'h0000_0107);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      ext_clk_tick = 1'($urandom % 2);
      @(negedge clk);
      if (adc_clk_en != ext_clk_tick) seen = 1;
    end
    chk(!seen, "R4 follow ext", seen, 0);
    ext_clk_tick = 1'b1;

    // R9 disabled: no power, no launch
    wr(32'h0000_0400);
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sample_start || ana_pwr_en) seen = 1;
    end
    chk(!seen, "R9 ignored when disabled", seen, 0);
    adc_en = 1'b1;
    @(negedge clk);
    chk(!ana_pwr_en, "R7 lp idle power off", ana_pwr_en, 0);

    // R8 low-power startup, 10-bit, divide 1
    res10 = 1'b1;
    wr(32'h0000_0401);
    trig_meas(0, lat);
    chk(lat == exp_lat(1, 0, 1, 1, 0), "R8 lp 10b latency", lat, exp_lat(1, 0, 1, 1, 0));
    chk(ana_pwr_en, "R7 power on in conversion", ana_pwr_en, 1);
    done_conv();
    chk(!ana_pwr_en, "R7 power off after done", ana_pwr_en, 0);
    res10 = 1'b0;

    // R10 pending trigger during conversion
    wr(32'h0000_0400);
    trig_meas(0, lat);
    chk(lat == 16, "R8 lp 12b latency", lat, 16);
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    done_conv();
    chk(ana_pwr_en, "R10 power held", ana_pwr_en, 1);
    @(negedge clk);
    chk(sample_start, "R10 pending served without wait", sample_start, 1);
    done_conv();
    chk(!ana_pwr_en, "R10 power off after last", ana_pwr_en, 0);

    // R13 held hw trigger counts once
    wr(32'h0000_0000);
    trig_meas(1, lat);
    chk(lat == 2, "R5 div0 latency", lat, 2);
    done_conv();
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sample_start) seen = 1; end
    chk(!seen, "R13 level not retrigger", seen, 0);
    hw_trig = 1'b0;
    @(negedge clk);

    // R6 bypass fixed launch
    sync_bypass = 1'b1;
    wr(32'h0000_0005);
    trig_meas(1, lat);
    chk(lat == 2, "R6 bypass latency", lat, 2);
    hw_trig = 1'b0;
    done_conv();
    sync_bypass = 1'b0;

    // R5/R6/R8 random configurations
    for (int t = 0; t < 16; t++) begin
      int dv; bit ex, lp, r1, by, hw;
      dv = $urandom % 8; ex = 1'($urandom % 2); lp = 1'($urandom % 2);
      r1 = 1'($urandom % 2); by = 1'($urandom % 2); hw = 1'($urandom % 2);
      res10 = r1; sync_bypass = by;
      wr({21'd0, lp, 1'b0, ex, 8'(dv)});
      trig_meas(hw, lat);
      chk(lat == exp_lat(dv, ex, lp, r1, by), "R5 random latency", lat,
          exp_lat(dv, ex, lp, r1, by));
      hw_trig = 1'b0;
      idle($urandom % 3);
      done_conv();
      chk(ana_pwr_en == !lp, "R7 power after done", ana_pwr_en, !lp);
      idle(2);
    end
    res10 = 0; sync_bypass = 0;

    // R11/R12 calibration and lock
    wr(32'h4000_0400);
    chk(cal_busy, "R11 busy after start", cal_busy, 1);
    wr(32'h0000_00AA);
    chk(reg_rdata == 32'h4000_0400, "R12 locked write", reg_rdata, 32'h4000_0400);
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    kk = 3;
    seen = 0;
    while (cal_busy && kk < 200) begin
      @(negedge clk);
      kk++;
      if (sample_start) seen = 1;
    end
    chk(kk == 66, "R11 calibration length", kk, 66);
    chk(reg_rdata == 32'h0000_0400, "R12 fields kept, bit cleared", reg_rdata, 32'h400);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sample_start) seen = 1; end
    chk(!seen, "R11 trigger ignored in calibration", seen, 0);
    chk(!ana_pwr_en, "R7 lp idle after calibration", ana_pwr_en, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule